// File: doc/BRIEF.md
# Vectored Interrupt Controller with Rotating Priority

This block collects up to 64 interrupt lines and presents them to a processor on two outputs, a normal interrupt (IRQ) and a fast interrupt (FIQ). Every source owns one control byte that holds its enable, its trigger mode and its destination code. Each input passes through a two-flop synchroniser. A source in level mode reports its synchronised input as its status bit. A source in edge mode latches a pending bit, which software clears by writing a one to that status bit.

For each output a priority register returns the number of the winning source among the enabled, active sources routed there. In fixed mode the lowest number wins. In rotating mode the source most recently reported by a read of that register drops to the lowest rank. With nothing active the register returns 63, so software tells an idle controller from a real source 63 by looking at bit 31 of the upper status word.

The register bus is addressed by 32-bit word and carries byte enables. A single control byte can therefore be changed without touching its three neighbours. Read data appears on the cycle after the request.

Top module: `vic_rot_top`

## Requirements
- R1: After a synchronous reset every control byte reads 0, both status words read 0 while the inputs are low, irq_o, fiq_o and bus_rdata are 0, and both priority registers read 0x3F (rotation off, code 63).
- R2: Control bytes for source n sit at byte offset 0x40+n (word address 16+n/4, byte lane n mod 4). Bits 2:0 hold the destination code, bit 3 the enable, bit 5 rising-edge mode and bit 6 falling-edge mode. Bits 4 and 7 always read 0. A write changes only the lanes whose byte enable is set.
- R3: With bits 5 and 6 both clear, a source is level-triggered (active high). Its status bit follows the synchronised input, and writing a 1 to that bit has no effect.
- R4: With bit 5 set, a low-to-high input transition sets the status bit. The bit stays set after the input returns low, and writing a 1 to it in the status word clears it. The status words are at word address 32 (sources 0 to 31, byte 0x80) and word address 33 (sources 32 to 63, byte 0x84).
- R5: With bit 6 set, a high-to-low input transition sets the status bit, and a rising transition does not.
- R6: A disabled source still latches edges into its status bit. It does not drive any output and is not reported by the priority registers.
- R7: irq_o is 1 when any enabled source with an active status bit has destination code 0, and fiq_o is 1 for destination code 1. Codes 2 to 7 drive neither output.
- R8: The IRQ priority register (word 8, byte 0x20) and the FIQ priority register (word 9, byte 0x24) return in bits 5:0 the number of the winning enabled active source routed to that output. In fixed mode the lowest-numbered source wins.
- R9: With no qualifying source, a priority register returns 63 in bits 5:0. Status bit 31 of the upper word separates that case from a real source 63.
- R10: Bit 6 of a priority register is a read/write rotation enable for that output only. With it set, each read that reports source k causes the next reads to search upward from k+1, wrapping past 63 to 0. Before the first such read the search starts at source 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Asynchronous interrupt inputs, one per source |
| bus_en | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_waddr | input | 6 | 32-bit word address |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
The assertions assume that reset is held high for the first clock edge and that the bus presents at most one access per cycle with defined control levels. The rotation and idle-code checks also assume that a priority register is read only as a whole word. The bench drives bus signals and source inputs only at falling clock edges and holds each source level for several cycles, so that no transition is lost in the synchroniser. Each sweep walks all 64 sources through edge mode on IRQ and level mode on FIQ. Further directed cases cover falling edges, disabled latching, the unused destination codes, the idle code and rotation with wrap-around.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // word addresses on the register bus (byte offset / 4)
  localparam logic [5:0] PRI_BASE  = 6'd8;   // 0x20 IRQ, 0x24 FIQ
  localparam logic [5:0] CTRL_BASE = 6'd16;  // 0x40 .. 0x7F
  localparam logic [5:0] STAT_BASE = 6'd32;  // 0x80, 0x84

  // control byte fields
  localparam int EN_BIT   = 3;
  localparam int RISE_BIT = 5;
  localparam int FALL_BIT = 6;
  localparam logic [7:0] CTRL_KEEP = 8'h6F;

  // priority register field
  localparam int ROT_BIT = 6;

  // outputs actually built: 0 = IRQ, 1 = FIQ
  localparam int NDST = 2;
endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell (
  input  logic clk,
  input  logic rst,
  input  logic src_i,
  input  logic rise_en,
  input  logic fall_en,
  input  logic clr_i,
  output logic stat_o
);
  logic meta_q, sync_q, prev_q, pend_q;
  logic edge_mode, hit;

  assign edge_mode = rise_en | fall_en;
  assign hit = (rise_en & sync_q & ~prev_q) | (fall_en & ~sync_q & prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      meta_q <= src_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
      if (!edge_mode)  pend_q <= 1'b0;
      else if (hit)    pend_q <= 1'b1;   // a new edge beats a clear
      else if (clr_i)  pend_q <= 1'b0;
    end
  end

  assign stat_o = edge_mode ? pend_q : sync_q;

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && pend_q && !clr_i) |=> (pend_q || !edge_mode));

  // R4
  latch_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && hit) |=> (stat_o || !edge_mode));
endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
  parameter int NSRC = 64,
  parameter int IDW  = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req,
  input  logic            rot_en,
  input  logic            take,
  output logic [IDW-1:0]  win_o,
  output logic            any_o
);
  logic [IDW-1:0]  last_q;
  logic [NSRC-1:0] above, upper;

  function automatic logic [IDW-1:0] first_set(input logic [NSRC-1:0] v);
    logic [IDW-1:0] r;
    r = IDW'(NSRC - 1);
    for (int i = NSRC - 1; i >= 0; i--)
      if (v[i]) r = IDW'(i);
    return r;
  endfunction

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      above[i] = rot_en && (IDW'(i) > last_q);
    upper = req & above;
    any_o = |req;
    win_o = (|upper) ? first_set(upper) : first_set(req);
  end

  always_ff @(posedge clk) begin
    if (rst)                          last_q <= IDW'(NSRC - 1);
    else if (take && any_o && rot_en) last_q <= win_o;
  end

  // R8
  grant_valid_chk: assert property (@(posedge clk) disable iff (rst)
    any_o |-> req[win_o]);

  // R8
  fixed_low_chk: assert property (@(posedge clk) disable iff (rst)
    (any_o && !rot_en) |-> ((req & ~({NSRC{1'b1}} << win_o)) == '0));

  // R10
  rot_order_chk: assert property (@(posedge clk) disable iff (rst)
    (rot_en && (|upper)) |-> (win_o > last_q));
endmodule

// File: rtl/vic_rot_top.sv
module vic_rot_top
  import vic_pkg::*;
#(
  parameter int NSRC = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            bus_en,
  input  logic            bus_we,
  input  logic [5:0]      bus_waddr,
  input  logic [3:0]      bus_be,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam int IDW  = $clog2(NSRC);
  localparam int NCW  = NSRC / 4;
  localparam int NSTW = NSRC / 32;

  logic [7:0]      ctrl_q [NSRC];
  logic [NDST-1:0] rot_q;
  logic [NSRC-1:0] stat, clr;
  logic [NDST-1:0][NSRC-1:0] req;
  logic [IDW-1:0]  win  [NDST];
  logic [NDST-1:0] any, take;
  logic            wr, rd;

  assign wr = bus_en & bus_we;
  assign rd = bus_en & ~bus_we;

  // write-one-to-clear strobes and per-output request vectors
  always_comb begin
    for (int n = 0; n < NSRC; n++)
      clr[n] = wr && (bus_waddr == STAT_BASE + 6'(n / 32))
               && bus_be[(n % 32) / 8] && bus_wdata[n % 32];
    for (int d = 0; d < NDST; d++) begin
      take[d] = rd && (bus_waddr == PRI_BASE + 6'(d));
      for (int n = 0; n < NSRC; n++)
        req[d][n] = stat[n] & ctrl_q[n][EN_BIT] & (ctrl_q[n][2:0] == 3'(d));
    end
  end

  genvar gn, gd;
  generate
    for (gn = 0; gn < NSRC; gn++) begin : g_src
      vic_src_cell u_cell (
        .clk     (clk),
        .rst     (rst),
        .src_i   (src_i[gn]),
        .rise_en (ctrl_q[gn][RISE_BIT]),
        .fall_en (ctrl_q[gn][FALL_BIT]),
        .clr_i   (clr[gn]),
        .stat_o  (stat[gn])
      );
    end
    for (gd = 0; gd < NDST; gd++) begin : g_out
      vic_arb #(.NSRC(NSRC), .IDW(IDW)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .req    (req[gd]),
        .rot_en (rot_q[gd]),
        .take   (take[gd]),
        .win_o  (win[gd]),
        .any_o  (any[gd])
      );
    end
  endgenerate

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < NSRC; n++) ctrl_q[n] <= 8'h00;
      rot_q <= '0;
    end else if (wr) begin
      for (int k = 0; k < NCW; k++)
        if (bus_waddr == CTRL_BASE + 6'(k))
          for (int b = 0; b < 4; b++)
            if (bus_be[b]) ctrl_q[4*k+b] <= bus_wdata[8*b +: 8] & CTRL_KEEP;
      for (int d = 0; d < NDST; d++)
        if (bus_waddr == PRI_BASE + 6'(d) && bus_be[0])
          rot_q[d] <= bus_wdata[ROT_BIT];
    end
  end

  // registered read mux and outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
    end else begin
      irq_o <= any[0];
      fiq_o <= any[1];
      if (rd) begin
        bus_rdata <= '0;
        for (int d = 0; d < NDST; d++)
          if (bus_waddr == PRI_BASE + 6'(d))
            bus_rdata <= {25'd0, rot_q[d], 6'(win[d])};
        for (int k = 0; k < NCW; k++)
          if (bus_waddr == CTRL_BASE + 6'(k))
            for (int b = 0; b < 4; b++)
              bus_rdata[8*b +: 8] <= ctrl_q[4*k+b];
        for (int k = 0; k < NSTW; k++)
          if (bus_waddr == STAT_BASE + 6'(k))
            bus_rdata <= stat[32*k +: 32];
      end
    end
  end

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(any[0]));

  // R7
  fiq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fiq_o) |-> $past(any[1]));

  // R9
  idle_code_chk: assert property (@(posedge clk) disable iff (rst)
    (take[0] && !any[0]) |=> (bus_rdata[5:0] == 6'h3F));
endmodule

// File: tb/vic_rot_top_test.sv
module vic_rot_top_test;
  localparam int NSRC = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_i = '0;
  logic            bus_en = 1'b0, bus_we = 1'b0;
  logic [5:0]      bus_waddr = '0;
  logic [3:0]      bus_be = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  vic_rot_top #(.NSRC(NSRC)) uut (
    .clk(clk), .rst(rst), .src_i(src_i), .bus_en(bus_en), .bus_we(bus_we),
    .bus_waddr(bus_waddr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  always #2.5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_waddr = a; bus_be = be; bus_wdata = d;
    tick(1);
    bus_en = 0; bus_we = 0; bus_be = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_waddr = a;
    tick(1);
    bus_en = 0;
    d = bus_rdata;
  endtask

  task automatic set_ctrl(input int n, input logic [7:0] v);
    wr(6'(16 + n / 4), 4'(1 << (n % 4)), 32'(v) << (8 * (n % 4)));
  endtask

  task automatic stat_bit(input int n, output logic b);
    logic [31:0] d;
    rd(6'(32 + n / 32), d);
    b = d[n % 32];
  endtask

  task automatic w1c(input int n);
    wr(6'(32 + n / 32), 4'hF, 32'd1 << (n % 32));
  endtask

  function automatic int rot_next(input logic [NSRC-1:0] m, input int last);
    for (int i = 1; i <= NSRC; i++)
      if (m[(last + i) % NSRC]) return (last + i) % NSRC;
    return NSRC - 1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic b;
    logic [NSRC-1:0] m;
    int last, e;

    tick(3);
    rst = 0;
    tick(1);

    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 fiq", 32'(fiq_o), 0);
    chk("R1 rdata", bus_rdata, 0);
    for (int k = 0; k < 16; k++) begin
      rd(6'(16 + k), d);
      chk("R1 ctrl", d, 0);
    end
    rd(6'd32, d); chk("R1 stat lo", d, 0);
    rd(6'd33, d); chk("R1 stat hi", d, 0);
    rd(6'd8, d);  chk("R1 pri irq", d, 32'h3F);
    rd(6'd9, d);  chk("R1 pri fiq", d, 32'h3F);

    // R2 byte lanes and reserved bits
    wr(6'd20, 4'b0100, 32'hFFFF_FFFF);
    rd(6'd20, d); chk("R2 lane", d, 32'h006F_0000);
    wr(6'd20, 4'b0001, 32'h0000_0029);
    rd(6'd20, d); chk("R2 lane0", d, 32'h006F_0029);
    wr(6'd20, 4'hF, 32'h0);
    rd(6'd20, d); chk("R2 clear", d, 0);

    // R4/R7/R8 rising-edge sweep on IRQ over every source
    for (int n = 0; n < NSRC; n++) begin
      set_ctrl(n, 8'h28);
      src_i[n] = 1; tick(4);
      stat_bit(n, b); chk("R4 latch", 32'(b), 1);
      chk("R7 irq on", 32'(irq_o), 1);
      rd(6'd8, d); chk("R8 pri irq", d, 32'(n));
      src_i[n] = 0; tick(4);
      stat_bit(n, b); chk("R4 hold", 32'(b), 1);
      w1c(n); tick(2);
      stat_bit(n, b); chk("R4 w1c", 32'(b), 0);
      chk("R7 irq off", 32'(irq_o), 0);
      set_ctrl(n, 8'h00);
    end

    // R3/R7/R8 level sweep on FIQ over every source
    for (int n = 0; n < NSRC; n++) begin
      set_ctrl(n, 8'h09);
      src_i[n] = 1; tick(4);
      chk("R7 fiq on", 32'(fiq_o), 1);
      chk("R7 irq quiet", 32'(irq_o), 0);
      rd(6'd9, d); chk("R8 pri fiq", d, 32'(n));
      w1c(n); tick(2);
      stat_bit(n, b); chk("R3 w1c ignored", 32'(b), 1);
      src_i[n] = 0; tick(4);
      stat_bit(n, b); chk("R3 follows input", 32'(b), 0);
      chk("R7 fiq off", 32'(fiq_o), 0);
      set_ctrl(n, 8'h00);
    end

    // R5 falling edge
    set_ctrl(5, 8'h48);
    src_i[5] = 1; tick(4);
    stat_bit(5, b); chk("R5 no rise latch", 32'(b), 0);
    src_i[5] = 0; tick(4);
    stat_bit(5, b); chk("R5 fall latch", 32'(b), 1);
    chk("R5 irq", 32'(irq_o), 1);
    w1c(5); set_ctrl(5, 8'h00); tick(2);

    // R6 disabled source latches silently
    set_ctrl(10, 8'h20);
    src_i[10] = 1; tick(4); src_i[10] = 0; tick(4);
    stat_bit(10, b); chk("R6 latch", 32'(b), 1);
    chk("R6 no irq", 32'(irq_o), 0);
    rd(6'd8, d); chk("R6 not reported", d, 32'h3F);
    set_ctrl(10, 8'h28); tick(3);
    chk("R6 enable shows", 32'(irq_o), 1);
    w1c(10); set_ctrl(10, 8'h00); tick(2);

    // R7 other destination code
    set_ctrl(20, 8'h0B);
    src_i[20] = 1; tick(4);
    stat_bit(20, b); chk("R7 dest3 status", 32'(b), 1);
    chk("R7 dest3 irq", 32'(irq_o), 0);
    chk("R7 dest3 fiq", 32'(fiq_o), 0);
    src_i[20] = 0; set_ctrl(20, 8'h00); tick(4);

    // R9 idle code versus real source 63
    rd(6'd8, d); chk("R9 idle code", d, 32'h3F);
    rd(6'd33, d); chk("R9 idle bit31", 32'(d[31]), 0);
    set_ctrl(63, 8'h08);
    src_i[63] = 1; tick(4);
    rd(6'd8, d); chk("R9 real 63", d, 32'h3F);
    rd(6'd33, d); chk("R9 bit31 set", 32'(d[31]), 1);

    // R8 fixed priority among several
    m = '0;
    m[63] = 1;
    for (int k = 0; k < 3; k++) begin
      automatic int s = (k == 0) ? 3 : (k == 1) ? 17 : 40;
      set_ctrl(s, 8'h08);
      src_i[s] = 1;
      m[s] = 1;
    end
    tick(4);
    rd(6'd8, d); chk("R8 lowest wins", d, 32'd3);
    rd(6'd8, d); chk("R8 fixed repeat", d, 32'd3);

    // R10 rotation
    wr(6'd8, 4'h1, 32'h40);
    last = 63;
    for (int k = 0; k < 6; k++) begin
      e = rot_next(m, last);
      rd(6'd8, d); chk("R10 rotate", d, 32'h40 | 32'(e));
      last = e;
    end
    src_i[17] = 0; m[17] = 0; tick(4);
    for (int k = 0; k < 4; k++) begin
      e = rot_next(m, last);
      rd(6'd8, d); chk("R10 rotate after drop", d, 32'h40 | 32'(e));
      last = e;
    end
    rd(6'd9, d); chk("R10 fiq independent", d, 32'h3F);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule